// File: doc/BRIEF.md
# Short-Descriptor Page Table Walker

This block maps a 32-bit virtual address to a physical address by walking a two-level page table in memory. When a request is accepted, the walker issues a read for the first-level entry. It sorts that entry into one of four kinds: invalid, pointer to a second-level table, 1 MB section, or 16 MB supersection. It then looks up the entry's domain in a 32-bit domain control word.

For table pointers, the walker issues a second read and decodes a 4 KB or 64 KB page entry. Access permission and execute-never attributes are derived at both levels. A privileged-execute-never attribute is also derived. Its table-level form only exists when the configuration input `cfg_pxn_en` is set. The same input decides whether first-level type 3 is a reserved encoding or a section.

The result goes back on a valid/ready response channel. It is either a translated address with its attributes or a 4-bit fault status. Memory reads use a valid/ready request with a separate, variably delayed data return. Only one walk is in flight at a time.

Top module: `sdw_walker`

## Requirements
- R1: First-level descriptor bits [1:0] select the kind. 0 is invalid. 1 is a table pointer. 2 is a section. 3 is a section only when `cfg_pxn_en`=1. An invalid entry, or type 3 with `cfg_pxn_en`=0, returns a fault with code 5.
- R2: The first read address is `ttb_base[31:14]` followed by `req_vaddr[31:20]` followed by `2'b00`.
- R3: The domain field is bits [8:5] for table pointers and ordinary sections, and 0 for supersections. The access value is `dom_ctrl[2*domain+1 : 2*domain]`. A value of 0 or 2 returns code 9 for sections and supersections. It returns code 11 for table pointers, and no second read is made.
- R4: A section is a type 2 or 3 entry with bit 18 clear. Its address is desc[31:20] followed by va[19:0]. With bit 18 set it is a supersection, and its address is desc[31:24] followed by va[23:0]. For both, the AP output is {desc[15], desc[11:10]}, XN is desc[4], and the privileged-execute-never bit is desc[0].
- R5: The second read address is first-level desc[31:10] followed by va[19:12] followed by `2'b00`. Second-level type 0 returns fault code 7. Type 1 is a 64 KB page: address desc[31:16] followed by va[15:0], XN is desc[15]. Types 2 and 3 are a 4 KB page: address desc[31:12] followed by va[11:0], XN is desc[0]. For both page sizes AP is {desc[9], desc[5:4]}.
- R6: For a table pointer, the privileged-execute-never bit is first-level bit 2 when `cfg_pxn_en`=1, and 0 otherwise. When the bit is set and `req_priv`=1, effective XN is forced to 1. User accesses (`req_priv`=0) are unaffected.
- R7: When the domain value is 1 (client), an instruction fetch (`req_fetch`=1) with effective XN set returns code 13 for sections and 15 for pages. When the domain value is 3 (manager), no execute fault is raised, `rsp_mgr`=1 and `rsp_xn`=0.
- R8: On success, `rsp_fault`=0 and `rsp_code`=0. On a fault, `rsp_paddr`, `rsp_ap`, `rsp_xn` and `rsp_mgr` are all zero.
- R9: `req_ready` is high only when idle. A response stays valid and unchanged until `rsp_ready`. A memory request keeps its address until `mem_rd_ready`.
- R10: After reset, `req_ready`=1, `rsp_valid`=0 and `mem_rd_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, can accept |
| req_vaddr | input | 32 | Virtual address |
| req_priv | input | 1 | 1 = privileged access |
| req_fetch | input | 1 | 1 = instruction fetch |
| cfg_pxn_en | input | 1 | Enables privileged-execute-never decoding |
| ttb_base | input | 32 | Table base, bits [31:14] used |
| dom_ctrl | input | 32 | Sixteen 2-bit domain access values |
| mem_rd_valid | output | 1 | Memory read request |
| mem_rd_ready | input | 1 | Memory accepts request |
| mem_rd_addr | output | 32 | Descriptor address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Descriptor word |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Result accepted |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_code | output | 4 | Fault status (0 when no fault) |
| rsp_paddr | output | 32 | Physical address |
| rsp_ap | output | 3 | Access permission bits |
| rsp_xn | output | 1 | Effective execute-never |
| rsp_mgr | output | 1 | Manager domain, full access |

## Verification
The hardest case to reach is the combination of a table pointer, a client domain, a privileged fetch and the configuration bit. Here a bit from the first level must suppress execution of a page whose own entry allows it. It can only be reached by building a matching two-level table in the bench memory for each access.

The bench therefore sweeps every first-level shape and every second-level type. For each shape it crosses the feature setting, all four domain values, the privilege and fetch flags, and both attribute bits. It places the domain value in one of two fields so that the wrong domain index would fault. Memory handshake delay, read latency and response stalls all vary from one access to the next.

// File: rtl/sdw_pkg.sv
package sdw_pkg;
  localparam int AW     = 32;
  localparam int DOM_W  = 4;
  localparam int CODE_W = 4;
  localparam int AP_W   = 3;

  typedef enum logic [2:0] {
    S_IDLE, S_L1_REQ, S_L1_WAIT, S_L2_REQ, S_L2_WAIT, S_RESP
  } walk_st_e;

  typedef enum logic [1:0] {K_FAULT, K_TABLE, K_SECTION, K_SUPER} l1_kind_e;

  localparam logic [CODE_W-1:0] FC_NONE     = 4'd0;
  localparam logic [CODE_W-1:0] FC_L1_XLAT  = 4'd5;
  localparam logic [CODE_W-1:0] FC_L2_XLAT  = 4'd7;
  localparam logic [CODE_W-1:0] FC_SEC_DOM  = 4'd9;
  localparam logic [CODE_W-1:0] FC_PG_DOM   = 4'd11;
  localparam logic [CODE_W-1:0] FC_SEC_PERM = 4'd13;
  localparam logic [CODE_W-1:0] FC_PG_PERM  = 4'd15;

  typedef struct packed {
    l1_kind_e         kind;
    logic [DOM_W-1:0] dom;
    logic [AW-1:0]    paddr;
    logic [AP_W-1:0]  ap;
    logic             xn;
    logic             pxn;
    logic [AW-1:0]    nxt;
  } l1_info_t;

  typedef struct packed {
    logic            ok;
    logic [AW-1:0]   paddr;
    logic [AP_W-1:0] ap;
    logic            xn;
  } pg_info_t;

  function automatic logic [AW-1:0] l1_fetch_addr(input logic [AW-1:0] ttb,
                                                  input logic [AW-1:0] va);
    return {ttb[31:14], va[31:20], 2'b00};
  endfunction

  function automatic logic [AW-1:0] l2_fetch_addr(input logic [AW-1:0] d,
                                                  input logic [AW-1:0] va);
    return {d[31:10], va[19:12], 2'b00};
  endfunction

  function automatic logic [1:0] dom_bits(input logic [AW-1:0] dacr,
                                          input logic [DOM_W-1:0] dom);
    logic [AW-1:0] sh;
    sh = dacr >> {dom, 1'b0};
    return sh[1:0];
  endfunction
endpackage

// File: rtl/sdw_l1_decode.sv
module sdw_l1_decode
  import sdw_pkg::*;
(
  input  logic [AW-1:0] desc,
  input  logic [AW-1:0] va,
  input  logic          pxn_en,
  output l1_info_t      info
);
  always_comb begin
    info       = '0;
    info.kind  = K_FAULT;
    info.nxt   = l2_fetch_addr(desc, va);
    info.ap    = {desc[15], desc[11:10]};
    info.xn    = desc[4];
    info.dom   = desc[8:5];
    unique case (desc[1:0])
      2'd0: info.kind = K_FAULT;
      2'd1: begin
        info.kind = K_TABLE;
        info.pxn  = pxn_en & desc[2];
        info.ap   = '0;
        info.xn   = 1'b0;
      end
      default: begin
        if (desc[1:0] == 2'd3 && !pxn_en) begin
          info.kind = K_FAULT;
        end else if (desc[18]) begin
          info.kind  = K_SUPER;
          info.dom   = '0;
          info.paddr = {desc[31:24], va[23:0]};
          info.pxn   = desc[0];
        end else begin
          info.kind  = K_SECTION;
          info.paddr = {desc[31:20], va[19:0]};
          info.pxn   = desc[0];
        end
      end
    endcase
  end
endmodule

// File: rtl/sdw_l2_decode.sv
module sdw_l2_decode
  import sdw_pkg::*;
(
  input  logic [AW-1:0] desc,
  input  logic [AW-1:0] va,
  output pg_info_t      pg
);
  logic unused_l2;
  assign unused_l2 = ^{desc, va};

  always_comb begin
    pg    = '0;
    pg.ap = {desc[9], desc[5:4]};
    unique case (desc[1:0])
      2'd0: begin
        pg.ok = 1'b0;
        pg.ap = '0;
      end
      2'd1: begin
        pg.ok    = 1'b1;
        pg.paddr = {desc[31:16], va[15:0]};
        pg.xn    = desc[15];
      end
      default: begin
        pg.ok    = 1'b1;
        pg.paddr = {desc[31:12], va[11:0]};
        pg.xn    = desc[0];
      end
    endcase
  end
endmodule

// File: rtl/sdw_exec_check.sv
module sdw_exec_check
  import sdw_pkg::*;
(
  input  logic              xn,
  input  logic              pxn,
  input  logic              priv,
  input  logic              fetch,
  input  logic [1:0]        dom_val,
  input  logic              is_page,
  output logic              fault,
  output logic [CODE_W-1:0] code,
  output logic              xn_out,
  output logic              mgr
);
  logic xn_eff;
  always_comb begin
    mgr    = (dom_val == 2'd3);
    xn_eff = xn | (pxn & priv);
    fault  = !mgr && xn_eff && fetch;
    code   = fault ? (is_page ? FC_PG_PERM : FC_SEC_PERM) : FC_NONE;
    xn_out = mgr ? 1'b0 : xn_eff;
  end
endmodule

// File: rtl/sdw_walker.sv
module sdw_walker
  import sdw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_vaddr,
  input  logic        req_priv,
  input  logic        req_fetch,
  input  logic        cfg_pxn_en,
  input  logic [31:0] ttb_base,
  input  logic [31:0] dom_ctrl,
  output logic        mem_rd_valid,
  input  logic        mem_rd_ready,
  output logic [31:0] mem_rd_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic        rsp_fault,
  output logic [3:0]  rsp_code,
  output logic [31:0] rsp_paddr,
  output logic [2:0]  rsp_ap,
  output logic        rsp_xn,
  output logic        rsp_mgr
);
  walk_st_e          state;
  logic [AW-1:0]     va_q, dacr_q, rd_addr_q;
  logic              priv_q, fetch_q, pxn_en_q;
  l1_info_t          l1, l1_q;
  pg_info_t          pg;
  logic [1:0]        dv, dv_q;
  logic              chk_fault, chk_xn, chk_mgr, in_l2;
  logic [CODE_W-1:0] chk_code;

  logic unused_ttb;
  assign unused_ttb = ^ttb_base[13:0];

  sdw_l1_decode u_l1 (.desc(mem_rsp_data), .va(va_q), .pxn_en(pxn_en_q), .info(l1));
  sdw_l2_decode u_l2 (.desc(mem_rsp_data), .va(va_q), .pg(pg));

  assign dv    = dom_bits(dacr_q, l1.dom);
  assign in_l2 = (state == S_L2_WAIT);

  sdw_exec_check u_ex (
    .xn(in_l2 ? pg.xn : l1.xn), .pxn(in_l2 ? l1_q.pxn : l1.pxn),
    .priv(priv_q), .fetch(fetch_q), .dom_val(in_l2 ? dv_q : dv),
    .is_page(in_l2), .fault(chk_fault), .code(chk_code),
    .xn_out(chk_xn), .mgr(chk_mgr)
  );

  // Named events, observed by the bound checker
  logic ev_l1_done, ev_l1_fault, ev_dom_fault, ev_l2_done, ev_l2_fault;
  assign ev_l1_done   = (state == S_L1_WAIT) && mem_rsp_valid;
  assign ev_l1_fault  = ev_l1_done && (l1.kind == K_FAULT);
  assign ev_dom_fault = ev_l1_done && !ev_l1_fault && !dv[0];
  assign ev_l2_done   = in_l2 && mem_rsp_valid;
  assign ev_l2_fault  = ev_l2_done && !pg.ok;

  assign req_ready    = (state == S_IDLE);
  assign rsp_valid    = (state == S_RESP);
  assign mem_rd_valid = (state == S_L1_REQ) || (state == S_L2_REQ);
  assign mem_rd_addr  = rd_addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      va_q <= '0; dacr_q <= '0; rd_addr_q <= '0;
      priv_q <= 1'b0; fetch_q <= 1'b0; pxn_en_q <= 1'b0;
      l1_q <= '0; dv_q <= '0;
      rsp_fault <= 1'b0; rsp_code <= '0; rsp_paddr <= '0;
      rsp_ap <= '0; rsp_xn <= 1'b0; rsp_mgr <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (req_valid) begin
          va_q      <= req_vaddr;
          priv_q    <= req_priv;
          fetch_q   <= req_fetch;
          pxn_en_q  <= cfg_pxn_en;
          dacr_q    <= dom_ctrl;
          rd_addr_q <= l1_fetch_addr(ttb_base, req_vaddr);
          state     <= S_L1_REQ;
        end
        S_L1_REQ: if (mem_rd_ready) state <= S_L1_WAIT;
        S_L2_REQ: if (mem_rd_ready) state <= S_L2_WAIT;
        S_L1_WAIT: if (mem_rsp_valid) begin
          rsp_paddr <= '0; rsp_ap <= '0; rsp_xn <= 1'b0; rsp_mgr <= 1'b0;
          if (ev_l1_fault) begin
            rsp_fault <= 1'b1; rsp_code <= FC_L1_XLAT; state <= S_RESP;
          end else if (ev_dom_fault) begin
            rsp_fault <= 1'b1;
            rsp_code  <= (l1.kind == K_TABLE) ? FC_PG_DOM : FC_SEC_DOM;
            state     <= S_RESP;
          end else if (l1.kind == K_TABLE) begin
            l1_q      <= l1;
            dv_q      <= dv;
            rd_addr_q <= l1.nxt;
            state     <= S_L2_REQ;
          end else begin
            rsp_fault <= chk_fault;
            rsp_code  <= chk_code;
            if (!chk_fault) begin
              rsp_paddr <= l1.paddr; rsp_ap <= l1.ap;
              rsp_xn    <= chk_xn;   rsp_mgr <= chk_mgr;
            end
            state <= S_RESP;
          end
        end
        S_L2_WAIT: if (mem_rsp_valid) begin
          rsp_paddr <= '0; rsp_ap <= '0; rsp_xn <= 1'b0; rsp_mgr <= 1'b0;
          if (ev_l2_fault) begin
            rsp_fault <= 1'b1; rsp_code <= FC_L2_XLAT;
          end else begin
            rsp_fault <= chk_fault;
            rsp_code  <= chk_code;
            if (!chk_fault) begin
              rsp_paddr <= pg.paddr; rsp_ap <= pg.ap;
              rsp_xn    <= chk_xn;   rsp_mgr <= chk_mgr;
            end
          end
          state <= S_RESP;
        end
        S_RESP: if (rsp_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdw_walker_chk.sv
module sdw_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        mem_rd_valid,
  input logic        mem_rd_ready,
  input logic [31:0] mem_rd_addr,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic        rsp_fault,
  input logic [3:0]  rsp_code,
  input logic [31:0] rsp_paddr,
  input logic        rsp_mgr,
  input logic        rsp_xn,
  input logic        ev_l1_fault,
  input logic        ev_dom_fault,
  input logic        ev_l2_fault
);
  assert_l1_fault_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_l1_fault |=> rsp_valid && rsp_fault && rsp_code == 4'd5);

  assert_dom_fault_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dom_fault |=> rsp_valid && rsp_fault && (rsp_code == 4'd9 || rsp_code == 4'd11));

  assert_l2_fault_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_l2_fault |=> rsp_valid && rsp_fault && rsp_code == 4'd7);

  assert_mgr_no_xn_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_mgr |-> !rsp_xn && !rsp_fault);

  assert_fault_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_paddr == 32'd0 && !rsp_mgr && !rsp_xn);

  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_code) && $stable(rsp_paddr));

  assert_mem_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

  assert_idle_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rsp_valid && !mem_rd_valid);
endmodule

bind sdw_walker sdw_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
  .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
  .rsp_code(rsp_code), .rsp_paddr(rsp_paddr), .rsp_mgr(rsp_mgr), .rsp_xn(rsp_xn),
  .ev_l1_fault(ev_l1_fault), .ev_dom_fault(ev_dom_fault), .ev_l2_fault(ev_l2_fault)
);

// File: tb/sim_sdw_walker.sv
module sim_sdw_walker;
  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_priv = 0, req_fetch = 0, cfg_pxn_en = 0;
  logic [31:0] req_vaddr = 0, ttb_base = 0, dom_ctrl = 0;
  logic        req_ready, mem_rd_valid, mem_rd_ready = 0, mem_rsp_valid = 0;
  logic [31:0] mem_rd_addr, mem_rsp_data = 0;
  logic        rsp_valid, rsp_ready = 0, rsp_fault, rsp_xn, rsp_mgr;
  logic [3:0]  rsp_code;
  logic [31:0] rsp_paddr;
  logic [2:0]  rsp_ap;

  int tests = 0, fails = 0;
  logic [31:0] rng = 32'h1234_5678;
  logic [31:0] mem [logic [31:0]];
  logic [31:0] exp_addr [2];
  int          fetch_idx = 0;

  always #5 clk = ~clk;

  sdw_walker u0 (.*);

  function automatic logic [31:0] step(input logic [31:0] x);
    return x * 32'd1103515245 + 32'd12345;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  // memory model: random accept, 0..3 cycles of read latency
  initial begin
    logic hs = 0, waiting = 0;
    logic [31:0] a_l = 0;
    int lat = 0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 0;
      if (hs) begin
        hs = 0; waiting = 1; rng = step(rng); lat = int'(rng[17:16]);
      end
      if (waiting) begin
        if (lat == 0) begin
          mem_rsp_valid = 1;
          mem_rsp_data  = mem.exists(a_l) ? mem[a_l] : 32'd0;
          waiting = 0;
        end else lat--;
      end
      rng = step(rng);
      mem_rd_ready = mem_rd_valid && !waiting && !mem_rsp_valid && rng[20];
      if (mem_rd_ready) begin
        hs = 1; a_l = mem_rd_addr;
        if (fetch_idx < 2)
          check(fetch_idx == 0 ? "R2" : "R5", "read address", 64'(mem_rd_addr),
                64'(exp_addr[fetch_idx]));
        fetch_idx++;
      end
    end
  end

  initial begin
    #2_000_000;
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic walk(input int shape, input bit en, input bit [1:0] dv,
                      input bit priv, input bit fetch, input bit [1:0] xb, input int n);
    logic [31:0] va, d1, d2, ttb, dacr, e_pa;
    logic [1:0]  t1, l2t;
    bit          ss, is_tab, e_fault, e_mgr, e_xn, xn, pxn;
    logic [3:0]  e_code;
    logic [2:0]  e_ap;
    int          stall;
    va   = 32'h9E37_79B9 * n + 32'h0137;
    ttb  = 32'h0004_1ABC ^ (n << 14);
    d1   = 32'h5BD1_E995 * (n + 3);
    d2   = 32'hC2B2_AE35 * (n + 7);
    ss   = (shape == 6 || shape == 8);
    t1   = (shape == 0) ? 2'd0 : (shape <= 4) ? 2'd1 : (shape <= 6) ? 2'd2 : 2'd3;
    l2t  = 2'(shape - 1);
    d1[1:0] = t1; d1[8:5] = 4'd7; d1[4] = xb[0]; d1[2] = xb[1];
    if (t1 != 2'd1) d1[18] = ss;
    d2[1:0] = l2t; d2[15] = xb[0];
    // domain value placed only where the correct index would look
    dacr = (t1 >= 2 && ss) ? 32'(dv) : (32'(dv) << 14);
    mem.delete();
    exp_addr[0] = {ttb[31:14], va[31:20], 2'b00};
    exp_addr[1] = {d1[31:10], va[19:12], 2'b00};
    mem[exp_addr[0]] = d1;
    mem[exp_addr[1]] = d2;
    // expected result
    e_fault = 0; e_code = 0; e_pa = 0; e_ap = 0; e_xn = 0; e_mgr = 0;
    is_tab = (t1 == 2'd1); xn = 0; pxn = 0;
    if (t1 == 0 || (t1 == 3 && !en)) begin
      e_fault = 1; e_code = 4'd5;
    end else if (dv == 0 || dv == 2) begin
      e_fault = 1; e_code = is_tab ? 4'd11 : 4'd9;
    end else if (is_tab && l2t == 0) begin
      e_fault = 1; e_code = 4'd7;
    end else begin
      if (!is_tab) begin
        e_pa = ss ? {d1[31:24], va[23:0]} : {d1[31:20], va[19:0]};
        e_ap = {d1[15], d1[11:10]}; xn = d1[4]; pxn = d1[0];
      end else begin
        e_pa = (l2t == 1) ? {d2[31:16], va[15:0]} : {d2[31:12], va[11:0]};
        e_ap = {d2[9], d2[5:4]}; xn = (l2t == 1) ? d2[15] : d2[0];
        pxn = en && d1[2];
      end
      e_xn = xn || (pxn && priv);
      if (dv == 3) begin
        e_mgr = 1; e_xn = 0;
      end else if (e_xn && fetch) begin
        e_fault = 1; e_code = is_tab ? 4'd15 : 4'd13;
      end
      if (e_fault) begin e_pa = 0; e_ap = 0; e_xn = 0; end
    end
    // drive request
    @(negedge clk);
    fetch_idx = 0;
    req_vaddr = va; ttb_base = ttb; dom_ctrl = dacr; cfg_pxn_en = en;
    req_priv = priv; req_fetch = fetch; req_valid = 1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0; ttb_base = ~ttb; dom_ctrl = ~dacr; cfg_pxn_en = ~en;
    while (!rsp_valid) @(negedge clk);
    check("R8", "fault flag", 64'(rsp_fault), 64'(e_fault));
    check(e_code == 5 ? "R1" : e_code == 7 ? "R5" : e_code >= 13 ? "R7" : "R3",
          "code", 64'(rsp_code), 64'(e_code));
    check(is_tab ? "R5" : "R4", "paddr", 64'(rsp_paddr), 64'(e_pa));
    check(is_tab ? "R5" : "R4", "ap", 64'(rsp_ap), 64'(e_ap));
    check(pxn ? "R6" : "R7", "xn", 64'(rsp_xn), 64'(e_xn));
    check("R7", "mgr", 64'(rsp_mgr), 64'(e_mgr));
    rng = step(rng); stall = int'(rng[9:8]);
    repeat (stall) @(negedge clk);
    check("R9", "held response", 64'({rsp_valid, rsp_code, rsp_paddr}),
          64'({1'b1, e_code, e_pa}));
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    check("R9", "idle after accept", 64'(req_ready), 64'd1);
  endtask

  initial begin
    int n = 0;
    repeat (3) @(negedge clk);
    check("R10", "reset req_ready", 64'(req_ready), 64'd1);
    check("R10", "reset rsp_valid", 64'(rsp_valid), 64'd0);
    check("R10", "reset mem_rd_valid", 64'(mem_rd_valid), 64'd0);
    rst_n = 1;
    for (int shape = 0; shape < 9; shape++)
      for (int en = 0; en < 2; en++)
        for (int dv = 0; dv < 4; dv++)
          for (int pr = 0; pr < 2; pr++)
            for (int fe = 0; fe < 2; fe++)
              for (int xb = 0; xb < 4; xb++) begin
                walk(shape, en[0], dv[1:0], pr[0], fe[0], xb[1:0], n);
                n++;
              end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule